// File: doc/BRIEF.md
# Keyboard Matrix Column Port

This block gives software a register window onto an 8x8 key matrix. Software writes a column-select byte into the select register. It then reads the key register to learn which keys in that column are held down. An external source supplies the pressed state of all 64 keys as a flat vector. The block decodes the select byte and picks out the eight flags of the chosen column. It returns them inverted, so a held key reads as 0.

The select byte is an active-low one-hot code. A small state machine classifies each byte written to the select register and holds the result:

- `ST_NONE`: the byte is 0xFF, so no column is chosen.
- `ST_COL`: exactly one bit is cleared, and that bit names the column.
- `ST_BAD`: any other pattern.

The transitions are `T_TO_NONE`, `T_TO_COL` and `T_TO_BAD`. Each one is taken on any write to the select register, from whichever state the machine is in; the byte written picks the target. With no select write, the state holds. In `ST_NONE` and `ST_BAD` the key register reads 0xFF and exposes no matrix data. Only the low four address bits choose among the sixteen register slots. Every slot other than the key register reads back the last byte written to it.

Top module: `kbd_matrix_port`

## Requirements
- R1: After reset the select register reads 0xFF, the key register reads 0xFF whatever keys are held, slots 2 to 15 read 0x00, and `bus_rdata` is 0x00 before the first read.
- R2: A write to slot 0 stores the byte, and a later read of slot 0 returns it unchanged.
- R3: When the select byte has exactly one cleared bit at position c, a read of slot 1 returns a byte whose bit k is the inverse of `key_down[c*8+k]` (pressed reads 0, released reads 1).
- R4: When the select byte is 0xFF, or has two or more cleared bits, a read of slot 1 returns 0xFF for any key pattern.
- R5: A read asserted on `bus_rd` at a rising edge places its data on `bus_rdata` at that edge. `bus_rdata` keeps its value through cycles with `bus_rd` low.
- R6: Slots 2 to 15 each read back the last byte written to that slot.
- R7: A write to slot 1 has no effect: the key read-back still follows the select byte and `key_down` only.
- R8: Only `bus_addr[3:0]` selects the slot; the upper address bits are ignored, so every slot has aliases.
- R9: The key register samples `key_down` at the read edge. Later key changes do not alter `bus_rdata` until the next read.
- R10: On every select write the state machine moves to `ST_NONE` for 0xFF, to `ST_COL` for a single cleared bit, and to `ST_BAD` otherwise. It holds its state without a select write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 16 | Register address; only the low four bits decode |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Registered read data |
| key_down | input | 64 | Key flags, 1 = pressed; index = column*8 + row |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high in the same cycle. They also assume that `key_down` only needs to be stable at the read edge. The stimulus keeps to this:

- Every bus access occupies one strobe cycle, driven at the falling edge.
- Key patterns change only between accesses.
- All 256 select bytes are swept against several fixed patterns and a walking single key, so each valid column and every invalid code is seen.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
    localparam int KBD_COLS   = 8;
    localparam int KBD_ROWS   = 8;
    localparam int KBD_DW     = 8;
    localparam int KBD_SLOTS  = 16;
    localparam int KBD_OFF_W  = $clog2(KBD_SLOTS);
    localparam logic [KBD_OFF_W-1:0] OFF_SEL  = 4'h0;
    localparam logic [KBD_OFF_W-1:0] OFF_KEYS = 4'h1;

    typedef enum logic [1:0] {
        ST_NONE = 2'd0,
        ST_COL  = 2'd1,
        ST_BAD  = 2'd2
    } sel_state_e;
endpackage

// File: rtl/kbd_sel_decode.sv
module kbd_sel_decode #(
    parameter int W = 8,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  sel,
    output logic          is_none,
    output logic          is_one,
    output logic [IW-1:0] idx
);
    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] zeros;

    always_comb begin
        zeros = '0;
        idx   = '0;
        for (int i = 0; i < W; i++) begin
            if (!sel[i]) begin
                zeros = zeros + CW'(1);
                idx   = IW'(i);
            end
        end
        is_none = (zeros == '0);
        is_one  = (zeros == CW'(1));
    end
endmodule

// File: rtl/kbd_col_gather.sv
module kbd_col_gather #(
    parameter int COLS = 8,
    parameter int ROWS = 8,
    localparam int IW = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic [COLS*ROWS-1:0] keys,
    input  logic [IW-1:0]        col,
    output logic [ROWS-1:0]      col_n
);
    logic [ROWS-1:0] cols_n [COLS];

    for (genvar c = 0; c < COLS; c++) begin : g_col
        assign cols_n[c] = ~keys[c*ROWS +: ROWS];
    end

    always_comb begin
        col_n = '1;
        for (int c = 0; c < COLS; c++) begin
            if (col == IW'(c)) col_n = cols_n[c];
        end
    end
endmodule

// File: rtl/kbd_scratch.sv
module kbd_scratch #(
    parameter int SLOTS = 16,
    parameter int DW    = 8,
    parameter int FIRST = 2,
    localparam int OW = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [OW-1:0] off,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] slot_q [SLOTS];

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        if (s >= FIRST) begin : g_store
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                       slot_q[s] <= '0;
                else if (wr && off == OW'(s))     slot_q[s] <= wdata;
            end
        end else begin : g_hole
            assign slot_q[s] = '0;
        end
    end

    assign rdata = slot_q[off];
endmodule

// File: rtl/kbd_matrix_port.sv
module kbd_matrix_port
    import kbd_pkg::*;
#(
    parameter int BUS_AW = 16,
    parameter int COLS   = KBD_COLS,
    parameter int ROWS   = KBD_ROWS,
    localparam int IW    = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BUS_AW-1:0]    bus_addr,
    input  logic [ROWS-1:0]      bus_wdata,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    output logic [ROWS-1:0]      bus_rdata,
    input  logic [COLS*ROWS-1:0] key_down
);
    logic [KBD_OFF_W-1:0] off;
    logic [COLS-1:0]      sel_q;
    logic [IW-1:0]        col_q;
    sel_state_e           state_q, state_d;
    logic                 dec_none, dec_one;
    logic [IW-1:0]        dec_idx;
    logic [ROWS-1:0]      col_n;
    logic [ROWS-1:0]      scratch_rd;
    logic [ROWS-1:0]      rd_mux;
    logic                 sel_wr;

    assign off    = bus_addr[KBD_OFF_W-1:0];
    assign sel_wr = bus_wr && (off == OFF_SEL);

    kbd_sel_decode #(.W(COLS)) u_dec (
        .sel     (bus_wdata[COLS-1:0]),
        .is_none (dec_none),
        .is_one  (dec_one),
        .idx     (dec_idx)
    );

    kbd_col_gather #(.COLS(COLS), .ROWS(ROWS)) u_gather (
        .keys  (key_down),
        .col   (col_q),
        .col_n (col_n)
    );

    kbd_scratch #(.SLOTS(KBD_SLOTS), .DW(ROWS), .FIRST(2)) u_scratch (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr),
        .off   (off),
        .wdata (bus_wdata),
        .rdata (scratch_rd)
    );

    // next state: T_TO_NONE / T_TO_COL / T_TO_BAD on select write
    always_comb begin
        state_d = state_q;
        if (sel_wr) begin
            if (dec_none)     state_d = ST_NONE;
            else if (dec_one) state_d = ST_COL;
            else              state_d = ST_BAD;
        end
    end

    // state register with captured select byte and column
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_NONE;
            sel_q   <= '1;
            col_q   <= '0;
        end else begin
            state_q <= state_d;
            if (sel_wr) begin
                sel_q <= bus_wdata[COLS-1:0];
                col_q <= dec_idx;
            end
        end
    end

    // output selection by state
    always_comb begin
        rd_mux = scratch_rd;
        if (off == OFF_SEL) begin
            rd_mux = ROWS'(sel_q);
        end else if (off == OFF_KEYS) begin
            unique case (state_q)
                ST_COL:  rd_mux = col_n;
                ST_NONE: rd_mux = '1;
                ST_BAD:  rd_mux = '1;
                default: rd_mux = '1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    AST_NONE_IS_FF: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_NONE |-> sel_q == '1); // R10
    AST_COL_ONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_COL |-> $countones(sel_q) == COLS - 1); // R3
    AST_COL_POINTS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_COL |-> sel_q[col_q] == 1'b0); // R3
    AST_BAD_MULTI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_BAD |-> $countones(sel_q) < COLS - 1); // R10
    AST_INVALID_READS_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && off == OFF_KEYS && state_q != ST_COL) |=> bus_rdata == '1); // R4
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R5
    AST_SEL_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr |=> sel_q == $past(bus_wdata[COLS-1:0])); // R2
    AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr)); // R5
endmodule

// File: tb/kbd_matrix_port_tb_top.sv
`timescale 1ns/1ps
module kbd_matrix_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic [63:0] key_down = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    kbd_matrix_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .key_down(key_down)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [7:0] expect_keys(logic [7:0] sel, logic [63:0] k);
        int zeros = 0;
        int col = 0;
        for (int i = 0; i < 8; i++) if (!sel[i]) begin zeros++; col = i; end
        if (zeros != 1) return 8'hFF;
        return ~k[col*8 +: 8];
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R5 watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [63:0] pats [4];
        pats[0] = 64'h0123_4567_89AB_CDEF;
        pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
        pats[2] = 64'h0000_0000_0000_0000;
        pats[3] = 64'hA5C3_0F96_7E18_F00D;

        key_down = pats[0];
        repeat (3) @(negedge clk);
        chk("R1 rdata at reset", bus_rdata, 8'h00);
        rst_n = 1'b1;
        rd(16'h0000, v); chk("R1 select reset", v, 8'hFF);
        rd(16'h0001, v); chk("R1 keys reset", v, 8'hFF);
        for (int s = 2; s < 16; s++) begin
            rd(16'(s), v); chk("R1 slot reset", v, 8'h00);
        end

        // R2 R3 R4 R10: exhaustive select sweep
        for (int p = 0; p < 4; p++) begin
            key_down = pats[p];
            for (int s = 0; s < 256; s++) begin
                wr(16'h0000, 8'(s));
                rd(16'h0000, v); chk("R2 select readback", v, 8'(s));
                rd(16'h0001, v); chk("R3/R4/R10 key read", v, expect_keys(8'(s), pats[p]));
            end
        end

        // R3: walking single key over every column
        for (int i = 0; i < 64; i++) begin
            key_down = 64'd1 << i;
            for (int c = 0; c < 8; c++) begin
                wr(16'h0000, ~(8'd1 << c));
                rd(16'h0001, v);
                chk("R3 walking key", v, (c == i / 8) ? ~(8'd1 << (i % 8)) : 8'hFF);
            end
        end

        // R10: state holds with no select write
        key_down = pats[3];
        wr(16'h0000, 8'hEF);
        wr(16'h0005, 8'h00);
        rd(16'h0001, v); chk("R10 hold ST_COL", v, expect_keys(8'hEF, pats[3]));
        wr(16'h0000, 8'hE7);
        rd(16'h0001, v); chk("R10 to ST_BAD", v, 8'hFF);
        wr(16'h0000, 8'hFF);
        rd(16'h0001, v); chk("R10 to ST_NONE", v, 8'hFF);

        // R6: scratch slots
        for (int s = 2; s < 16; s++) wr(16'(s), 8'(s * 17 + 3));
        for (int s = 2; s < 16; s++) begin
            rd(16'(s), v); chk("R6 slot readback", v, 8'(s * 17 + 3));
        end

        // R7: writes to key slot ignored
        wr(16'h0001, 8'h00);
        rd(16'h0001, v); chk("R7 key write ignored none", v, 8'hFF);
        wr(16'h0000, 8'hFB);
        wr(16'h0001, 8'h55);
        rd(16'h0001, v); chk("R7 key write ignored col", v, expect_keys(8'hFB, pats[3]));
        rd(16'h0000, v); chk("R7 select intact", v, 8'hFB);

        // R8: address aliasing
        wr(16'hABC0, 8'h7F);
        rd(16'h0000, v); chk("R8 alias write sel", v, 8'h7F);
        rd(16'hFFF1, v); chk("R8 alias read keys", v, expect_keys(8'h7F, pats[3]));
        wr(16'h123A, 8'h9C);
        rd(16'h000A, v); chk("R8 alias slot", v, 8'h9C);

        // R5 R9: hold and sampling point
        rd(16'h0001, v);
        key_down = ~pats[3];
        repeat (3) @(negedge clk);
        chk("R9 keys sampled at read", bus_rdata, expect_keys(8'h7F, pats[3]));
        wr(16'h0004, 8'h11);
        chk("R5 rdata held", bus_rdata, expect_keys(8'h7F, pats[3]));
        rd(16'h0001, v); chk("R9 new read sees new keys", v, expect_keys(8'h7F, ~pats[3]));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule